// File: doc/BRIEF.md
# Staged Control Register Bank

This block holds the sixteen 16-bit control registers of a small processor core: the status word, the program counter with backup and debug copies, the repeat-loop count and bounds, the modulo addressing bounds and an instruction break address. Any register can be read through one port. Writes go through a second port and never land at once. Each write carries an index, a value, a keep mask and a source flag that marks it as coming from hardware or from software.

Accepted writes wait in a small ordered queue. A commit strobe at the end of an instruction applies every waiting write to the registers in the order the writes arrived and then empties the queue. A drop strobe empties the queue and applies nothing. Because of this, an instruction that faults can be cancelled cleanly, and reads made during the instruction return only the values committed before it.

Top module: `ctlrf_bank`

## Requirements
- R1: While reset is high and on the cycle after it falls, every index reads as zero, the queue is empty and `ovf_err` is low.
- R2: `rd_data` is registered. It shows the committed value of register `rd_idx` one clock after `rd_idx` is presented. A write still waiting in the queue does not change what is read.
- R3: Each write applies new = (old AND keep) OR (value AND NOT keep), so a keep bit of 1 leaves that register bit unchanged.
- R4: On commit, queued writes are applied in arrival order. For the same register, a later write acts on the result of the earlier ones.
- R5: `drop` empties the queue and no queued write reaches a register.
- R6: A software write (`wr_hw`=0) to index 0, the status word, has its value ANDed with 0xBFCD. This clears value bits 14, 5, 4 and 1. A hardware write to index 0 is not filtered. A hardware write whose keep mask is all ones except one bit changes only that bit.
- R7: Indices 6, 12, 13 and 15 always read as zero. Writes to them are ignored and take no queue slot.
- R8: The queue holds 16 writes. An accepted write that arrives while the queue is full is lost and sets `ovf_err`. `ovf_err` stays set until the next `commit` or `drop`.
- R9: A write presented in the same cycle as `commit` is applied as the last write of that batch. A write presented with `drop` is discarded. When `commit` and `drop` are both high, `drop` wins.
- R10: After a commit the queue again accepts 16 writes without raising `ovf_err`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_idx | input | 4 | Register index to read |
| rd_data | output | 16 | Committed value of the register selected on the previous clock |
| wr_en | input | 1 | Write request |
| wr_idx | input | 4 | Register index to write |
| wr_val | input | 16 | Write value |
| wr_keep | input | 16 | Keep mask; a 1 bit keeps the old bit |
| wr_hw | input | 1 | 1 = hardware-originated write (no status filtering) |
| commit | input | 1 | Apply all queued writes in order, then empty the queue |
| drop | input | 1 | Empty the queue without applying |
| ovf_err | output | 1 | A write was lost to a full queue since the last commit or drop |

## Verification
The hardest state to reach from the ports is a full queue. It needs sixteen accepted writes with no strobe in between before the seventeenth write can show the overflow. The stimulus gets there by issuing sixteen increasing values to one register followed by a marker value. The check then confirms that the register ends at the sixteenth value, that the flag is set, and that the queue refills cleanly after the commit. Writes that arrive in the same cycle as a strobe are driven directly, to test their ordering against the batch.

// File: rtl/ctlrf_pkg.sv
`timescale 1ns/1ps
package ctlrf_pkg;
  localparam int unsigned CR_DW    = 16;
  localparam int unsigned CR_AW    = 4;
  localparam int unsigned CR_NREG  = 1 << CR_AW;
  // indices that hold storage: 0-5, 7-11, 14
  localparam logic [CR_NREG-1:0] CR_IMPL_MAP = 16'h4FBF;
  localparam logic [CR_AW-1:0]   CR_STATUS_IDX = '0;
  // implemented status bits: 15,13,12,11,10,9,8,7,6,3,2,0
  localparam logic [CR_DW-1:0]   CR_STATUS_IMPL = 16'hBFCD;

  typedef struct packed {
    logic [CR_AW-1:0] idx;
    logic [CR_DW-1:0] val;
    logic [CR_DW-1:0] keep;
  } cr_upd_t;
endpackage

// File: rtl/ctlrf_queue.sv
`timescale 1ns/1ps
module ctlrf_queue
  import ctlrf_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          push,
  input  cr_upd_t                       push_ent,
  input  logic                          clear,
  output cr_upd_t [DEPTH-1:0]           ents,
  output logic [$clog2(DEPTH+1)-1:0]    cnt,
  output logic                          full
);
  localparam int unsigned CW = $clog2(DEPTH+1);
  localparam int unsigned IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  cr_upd_t [DEPTH-1:0] ent_q;
  logic [CW-1:0]       cnt_q;

  assign full = (cnt_q == CW'(DEPTH));
  assign ents = ent_q;
  assign cnt  = cnt_q;

  // entry storage carries no reset so it maps onto plain memory
  always_ff @(posedge clk) begin
    if (push && !full && !clear)
      ent_q[cnt_q[IW-1:0]] <= push_ent;
  end

  always_ff @(posedge clk) begin
    if (rst || clear)
      cnt_q <= '0;
    else if (push && !full)
      cnt_q <= cnt_q + 1'b1;
  end

  p_cnt_bound_r8: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(DEPTH));
  p_clear_empties_r5: assert property (@(posedge clk) disable iff (rst)
    clear |=> (cnt_q == '0));
  p_full_holds_r8: assert property (@(posedge clk) disable iff (rst)
    (full && !clear) |=> full);
endmodule

// File: rtl/ctlrf_apply.sv
`timescale 1ns/1ps
module ctlrf_apply
  import ctlrf_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned NREG  = CR_NREG
) (
  input  logic [NREG-1:0][CR_DW-1:0]    cur,
  input  cr_upd_t [DEPTH-1:0]           ents,
  input  logic [$clog2(DEPTH+1)-1:0]    cnt,
  input  logic                          tail_vld,
  input  cr_upd_t                       tail,
  output logic [NREG-1:0][CR_DW-1:0]    nxt
);
  // fold queued updates in arrival order, the same-cycle write last
  always_comb begin
    nxt = cur;
    for (int s = 0; s < DEPTH; s++) begin
      if (s < int'(cnt))
        nxt[ents[s].idx] = (nxt[ents[s].idx] & ents[s].keep)
                         | (ents[s].val & ~ents[s].keep);
    end
    if (tail_vld)
      nxt[tail.idx] = (nxt[tail.idx] & tail.keep) | (tail.val & ~tail.keep);
  end
endmodule

// File: rtl/ctlrf_store.sv
`timescale 1ns/1ps
module ctlrf_store
  import ctlrf_pkg::*;
#(
  parameter int unsigned        NREG = CR_NREG,
  parameter logic [NREG-1:0]    IMPL = CR_IMPL_MAP
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          load,
  input  logic [NREG-1:0][CR_DW-1:0]    nxt,
  input  logic [$clog2(NREG)-1:0]       rd_idx,
  output logic [NREG-1:0][CR_DW-1:0]    cur,
  output logic [CR_DW-1:0]              rd_data
);
  logic [NREG-1:0][CR_DW-1:0] reg_q;

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    if (IMPL[r]) begin : g_hold
      always_ff @(posedge clk) begin
        if (rst)       reg_q[r] <= '0;
        else if (load) reg_q[r] <= nxt[r];
      end
    end else begin : g_none
      assign reg_q[r] = '0;
    end
  end

  assign cur = reg_q;

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= reg_q[rd_idx];
  end

  p_hold_without_load_r2: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(reg_q));
  p_unused_reads_zero_r7: assert property (@(posedge clk) disable iff (rst)
    !IMPL[rd_idx] |=> (rd_data == '0));
endmodule

// File: rtl/ctlrf_bank.sv
`timescale 1ns/1ps
module ctlrf_bank
  import ctlrf_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CR_AW-1:0]  rd_idx,
  output logic [CR_DW-1:0]  rd_data,
  input  logic              wr_en,
  input  logic [CR_AW-1:0]  wr_idx,
  input  logic [CR_DW-1:0]  wr_val,
  input  logic [CR_DW-1:0]  wr_keep,
  input  logic              wr_hw,
  input  logic              commit,
  input  logic              drop,
  output logic              ovf_err
);
  localparam int unsigned CW = $clog2(DEPTH+1);

  cr_upd_t                     in_ent;
  cr_upd_t [DEPTH-1:0]         q_ents;
  logic [CW-1:0]               q_cnt;
  logic                        q_full;
  logic                        accept, apply_en, tail_vld, push, lost;
  logic [CR_NREG-1:0][CR_DW-1:0] cur, nxt;
  logic                        err_q;

  always_comb begin
    in_ent.idx  = wr_idx;
    in_ent.keep = wr_keep;
    in_ent.val  = (!wr_hw && wr_idx == CR_STATUS_IDX) ? (wr_val & CR_STATUS_IMPL)
                                                       : wr_val;
  end

  assign accept   = wr_en && CR_IMPL_MAP[wr_idx];
  assign apply_en = commit && !drop;
  assign lost     = accept && q_full && !drop;
  assign push     = accept && !commit && !drop;
  assign tail_vld = accept && apply_en && !q_full;

  ctlrf_queue #(.DEPTH(DEPTH)) u_queue (
    .clk(clk), .rst(rst), .push(push), .push_ent(in_ent),
    .clear(commit || drop), .ents(q_ents), .cnt(q_cnt), .full(q_full)
  );

  ctlrf_apply #(.DEPTH(DEPTH), .NREG(CR_NREG)) u_apply (
    .cur(cur), .ents(q_ents), .cnt(q_cnt), .tail_vld(tail_vld),
    .tail(in_ent), .nxt(nxt)
  );

  ctlrf_store #(.NREG(CR_NREG), .IMPL(CR_IMPL_MAP)) u_store (
    .clk(clk), .rst(rst), .load(apply_en), .nxt(nxt), .rd_idx(rd_idx),
    .cur(cur), .rd_data(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst)                  err_q <= 1'b0;
    else if (lost)            err_q <= 1'b1;
    else if (commit || drop)  err_q <= 1'b0;
  end
  assign ovf_err = err_q;

  p_overflow_flags_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && CR_IMPL_MAP[wr_idx] && q_full && !drop) |=> ovf_err);
  p_drop_keeps_regs_r5: assert property (@(posedge clk) disable iff (rst)
    drop |=> $stable(cur));
  p_err_needs_full_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf_err) |-> $past(q_full));
endmodule

// File: tb/ctlrf_bank_tb.sv
`timescale 1ns/1ps
module ctlrf_bank_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  rd_idx = '0;
  logic [15:0] rd_data;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_idx = '0;
  logic [15:0] wr_val = '0;
  logic [15:0] wr_keep = '0;
  logic        wr_hw = 1'b0;
  logic        commit = 1'b0;
  logic        drop = 1'b0;
  logic        ovf_err;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  ctlrf_bank u_dut (
    .clk(clk), .rst(rst), .rd_idx(rd_idx), .rd_data(rd_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_val(wr_val), .wr_keep(wr_keep),
    .wr_hw(wr_hw), .commit(commit), .drop(drop), .ovf_err(ovf_err)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one cycle write, optionally with strobes in the same cycle
  task automatic put(input logic [3:0] i, input logic [15:0] v, input logic [15:0] k,
                     input logic hw, input logic c = 0, input logic d = 0);
    @(negedge clk);
    wr_en = 1; wr_idx = i; wr_val = v; wr_keep = k; wr_hw = hw; commit = c; drop = d;
    @(negedge clk);
    wr_en = 0; commit = 0; drop = 0;
  endtask

  task automatic strobe(input logic c, input logic d);
    @(negedge clk);
    commit = c; drop = d;
    @(negedge clk);
    commit = 0; drop = 0;
  endtask

  task automatic rd(input logic [3:0] i, output logic [15:0] v);
    @(negedge clk);
    rd_idx = i;
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    for (int i = 0; i < 16; i++) begin
      rd(4'(i), v);
      check("R1 reset read", v, 16'h0);
    end
    check("R1 reset ovf_err", {15'h0, ovf_err}, 16'h0);
  endtask

  task automatic t_merge();
    logic [15:0] v;
    put(4'd2, 16'h1234, 16'h0000, 0); strobe(1, 0);
    rd(4'd2, v); check("R3 full write", v, 16'h1234);
    put(4'd2, 16'hABCD, 16'hFF00, 0); strobe(1, 0);
    rd(4'd2, v); check("R3 keep upper byte", v, 16'h12CD);
  endtask

  task automatic t_pending();
    logic [15:0] v;
    put(4'd3, 16'h5555, 16'h0000, 0);
    rd(4'd3, v); check("R2 pending invisible", v, 16'h0000);
    strobe(1, 0);
    rd(4'd3, v); check("R2 visible after commit", v, 16'h5555);
  endtask

  task automatic t_order();
    logic [15:0] v;
    put(4'd8, 16'h1111, 16'h0000, 0);
    put(4'd8, 16'h2222, 16'h0000, 1);
    put(4'd8, 16'hFFFF, 16'hFFF0, 0);
    strobe(1, 0);
    rd(4'd8, v); check("R4 ordered fold", v, 16'h222F);
  endtask

  task automatic t_drop();
    logic [15:0] v;
    put(4'd9, 16'h7777, 16'h0000, 0);
    strobe(0, 1); strobe(1, 0);
    rd(4'd9, v); check("R5 dropped write", v, 16'h0000);
  endtask

  task automatic t_status();
    logic [15:0] v;
    put(4'd0, 16'hFFFF, 16'h0000, 0); strobe(1, 0);
    rd(4'd0, v); check("R6 software filtered", v, 16'hBFCD);
    put(4'd0, 16'hFFFF, 16'h0000, 1); strobe(1, 0);
    rd(4'd0, v); check("R6 hardware unfiltered", v, 16'hFFFF);
    put(4'd0, 16'h0000, 16'hFFBF, 1); strobe(1, 0);
    rd(4'd0, v); check("R6 single bit clear", v, 16'hFFBF);
    put(4'd0, 16'h0000, 16'hFFFE, 0); strobe(1, 0);
    rd(4'd0, v); check("R6 software keep unimpl", v, 16'hFFBE);
  endtask

  task automatic t_unused();
    logic [15:0] v;
    put(4'd6, 16'hFFFF, 16'h0000, 1);
    put(4'd12, 16'hFFFF, 16'h0000, 1);
    put(4'd13, 16'hFFFF, 16'h0000, 0);
    put(4'd15, 16'hFFFF, 16'h0000, 0);
    for (int i = 1; i <= 16; i++) put(4'd10, 16'(i), 16'h0000, 0);
    check("R7 no slot taken", {15'h0, ovf_err}, 16'h0);
    strobe(1, 0);
    rd(4'd10, v); check("R7 neighbour committed", v, 16'd16);
    rd(4'd6, v);  check("R7 idx6 zero", v, 16'h0);
    rd(4'd12, v); check("R7 idx12 zero", v, 16'h0);
    rd(4'd13, v); check("R7 idx13 zero", v, 16'h0);
    rd(4'd15, v); check("R7 idx15 zero", v, 16'h0);
  endtask

  task automatic t_overflow();
    logic [15:0] v;
    for (int i = 1; i <= 16; i++) put(4'd11, 16'(i), 16'h0000, 0);
    check("R8 full no error yet", {15'h0, ovf_err}, 16'h0);
    put(4'd11, 16'hDEAD, 16'h0000, 0);
    check("R8 overflow flag", {15'h0, ovf_err}, 16'h1);
    strobe(1, 0);
    check("R8 flag cleared", {15'h0, ovf_err}, 16'h0);
    rd(4'd11, v); check("R8 extra write lost", v, 16'd16);
    for (int i = 0; i < 16; i++) put(4'd1, 16'(i + 100), 16'h0000, 0);
    check("R10 refill no error", {15'h0, ovf_err}, 16'h0);
    strobe(1, 0);
    rd(4'd1, v); check("R10 refill committed", v, 16'd115);
  endtask

  task automatic t_same_cycle();
    logic [15:0] v;
    put(4'd7, 16'h0AAA, 16'h0000, 0, 1, 0);
    rd(4'd7, v); check("R9 write with commit", v, 16'h0AAA);
    put(4'd7, 16'h0BBB, 16'h0000, 0, 0, 1);
    strobe(1, 0);
    rd(4'd7, v); check("R9 write with drop", v, 16'h0AAA);
    put(4'd7, 16'h0CCC, 16'h0000, 0);
    put(4'd14, 16'h0DDD, 16'h0000, 0, 1, 1);
    rd(4'd7, v);  check("R9 drop wins queued", v, 16'h0AAA);
    rd(4'd14, v); check("R9 drop wins same-cycle", v, 16'h0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_merge();
    t_pending();
    t_order();
    t_drop();
    t_status();
    t_unused();
    t_overflow();
    t_same_cycle();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule